// File: doc/BRIEF.md
# CAN FD Transmit Buffer Scheduler

This block decides which of a set of transmit message buffers goes onto the bus next. Software marks buffers as pending by writing ones into a ready mask. It withdraws pending buffers by writing ones into a cancel mask. The identifier and control word of every buffer arrive on flattened input arrays. The block picks the pending buffer with the numerically lowest identifier and raises a one-cycle launch strobe carrying that buffer's index. It then waits for the frame engine to acknowledge completion.

When a completed buffer asks for it, the block writes an event record into a small circular event log, which software reads and advances. A full log drops the record and pulses an overflow flag. Serial framing and payload storage live elsewhere.

The control sequencer has three states:

- `ST_IDLE` waits for a permitted launch. It takes the transition *idle-to-launch* when transmission is allowed and at least one uncancelled buffer is pending, and it latches the winner at that moment.
- `ST_LAUNCH` holds the strobe for exactly one cycle. It always takes *launch-to-busy*.
- `ST_BUSY` waits for `tx_done`. On it, the transition *busy-to-idle* retires the buffer and logs its event.

Top module: `canfd_tx_sched`

## Requirements
- R1: A ready-mask write with `rdy_wr` high sets every `ready_req` bit whose `rdy_wdata` bit is one. Zero bits leave their buffer unchanged. The new bits appear after the clock edge that samples the write.
- R2: A buffer that is not in flight and has both its ready and its cancel bit set has both bits cleared at the next edge. `cancel_irq` is then high for exactly one cycle. A cancel written to a pending idle buffer is served at the same edge that samples the write.
- R3: A cancel write to a buffer whose ready bit is zero is discarded: `cancel_req` stays zero for that buffer and no `cancel_irq` follows. At any time, `cancel_req` is a subset of `ready_req`.
- R4: Among pending, uncancelled buffers, the winner is the one with the lowest identifier, and equal identifiers go to the lowest index. `launch` is a single-cycle strobe with the winner on `launch_idx`. It is raised two edges after the ready write when the block is idle.
- R5: No launch begins while `soft_rst` is high, `core_en` is low, or `snoop_en` is high. Pending bits are kept.
- R6: While `snoop_en` is high, ready-mask writes are ignored, so a zero `ready_req` stays zero.
- R7: `tx_done` in the busy state clears the ready and cancel bits of the launched buffer and returns the sequencer to idle. A cancel written to the in-flight buffer is held pending without an interrupt and is cleared at completion.
- R8: A completed buffer whose control bit 6 (log enable) is set stores an event record into the log. The control word holds the data-length code in bits 3:0, the FD-format flag in bit 4, the bit-rate-switch flag in bit 5 and the marker in bits 14:7. The record carries the identifier, data-length code, both flags, the marker, an event type of 3, and the `ts_in` value of the completion cycle.
- R9: A record arriving while the log holds `EVT_DEPTH` entries is dropped, and `evt_ovf_irq` is high for one cycle. A read at the same edge does not make room for it.
- R10: A read strobe on a non-empty log advances `evt_rd_idx` modulo `EVT_DEPTH` and lowers `evt_fill` by one. On an empty log it is ignored. The head record appears on the `evt_*` outputs whenever `evt_fill` is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Software reset request; blocks new launches |
| core_en | input | 1 | Core enable; launches only when high |
| snoop_en | input | 1 | Listen-only mode; blocks launches and ready writes |
| rdy_wr | input | 1 | Ready-mask write strobe |
| rdy_wdata | input | NBUF | Ready-mask write data, one bit per buffer |
| cxl_wr | input | 1 | Cancel-mask write strobe |
| cxl_wdata | input | NBUF | Cancel-mask write data |
| buf_id_flat | input | NBUF*ID_W | Identifier of every buffer, buffer i at bits i*ID_W |
| buf_ctrl_flat | input | NBUF*CTRL_W | Control word of every buffer |
| ts_in | input | TS_W | Current timestamp |
| tx_done | input | 1 | Completion acknowledge from the frame engine |
| evt_rd_inc | input | 1 | Event log read-advance strobe |
| ready_req | output | NBUF | Pending buffers |
| cancel_req | output | NBUF | Cancel requests not yet served |
| launch | output | 1 | One-cycle start strobe |
| launch_idx | output | IDX_W | Buffer index being launched or in flight |
| cancel_irq | output | 1 | Cancellation served pulse |
| evt_ovf_irq | output | 1 | Event record dropped pulse |
| evt_fill | output | CNT_W | Records held in the log |
| evt_rd_idx | output | PTR_W | Log read index |
| evt_id | output | ID_W | Head record identifier |
| evt_dlc | output | DLC_W | Head record data-length code |
| evt_fdf | output | 1 | Head record FD-format flag |
| evt_brs | output | 1 | Head record bit-rate-switch flag |
| evt_type | output | 2 | Head record event type |
| evt_marker | output | MM_W | Head record marker |
| evt_ts | output | TS_W | Head record timestamp |

## Verification
Two kinds of wrong internal state show up at the ports within one cycle. A corrupted pending or cancel mask appears on `ready_req` or `cancel_req` at the next edge. A wrong winner shows as a wrong `launch_idx` on the first launch strobe after the fault.

Faults in the event log take longer to surface. A bad write pointer or fill count stays hidden until that slot reaches the head. Pops are therefore interleaved with pushes and carried past the wrap, so every slot is read back.

A sequencer that skips or repeats a state shows up as a strobe that is early, missing or two cycles long. It can also show as a ready bit that never clears after `tx_done`.

// File: rtl/canfd_txs_pkg.sv
package canfd_txs_pkg;
    parameter int ID_W   = 29;
    parameter int DLC_W  = 4;
    parameter int MM_W   = 8;
    parameter int TS_W   = 16;
    parameter int CTRL_W = DLC_W + 3 + MM_W;

    // control word field positions
    localparam int CB_FDF = DLC_W;
    localparam int CB_BRS = DLC_W + 1;
    localparam int CB_LOG = DLC_W + 2;
    localparam int CB_MM  = DLC_W + 3;

    localparam logic [1:0] EVT_KIND_SENT = 2'd3;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_BUSY   = 2'd2
    } txs_state_e;

    typedef struct packed {
        logic [ID_W-1:0]  id;
        logic [DLC_W-1:0] dlc;
        logic             fdf;
        logic             brs;
        logic [1:0]       kind;
        logic [MM_W-1:0]  marker;
        logic [TS_W-1:0]  ts;
    } txs_evt_t;
endpackage

// File: rtl/txs_arbiter.sv
module txs_arbiter #(
    parameter int NBUF = 32,
    parameter int ID_W = 29,
    localparam int IDX_W = (NBUF > 1) ? $clog2(NBUF) : 1
) (
    input  logic [NBUF-1:0]      cand,
    input  logic [NBUF*ID_W-1:0] ids,
    output logic                 found,
    output logic [IDX_W-1:0]     win
);
    logic [ID_W-1:0] best;

    // strict less-than keeps the earliest index on equal identifiers
    always_comb begin
        found = 1'b0;
        win   = '0;
        best  = '1;
        for (int i = 0; i < NBUF; i++) begin
            if (cand[i] && (!found || (ids[i*ID_W +: ID_W] < best))) begin
                found = 1'b1;
                best  = ids[i*ID_W +: ID_W];
                win   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/txs_evt_fifo.sv
module txs_evt_fifo
    import canfd_txs_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  txs_evt_t         push_data,
    input  logic             pop,
    output logic [CNT_W-1:0] fill,
    output logic [PTR_W-1:0] rd_idx,
    output txs_evt_t         head,
    output logic             ovf
);
    txs_evt_t          slot [DEPTH];
    logic [PTR_W-1:0]  ri_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              full, empty, acc, take;
    logic [PTR_W-1:0]  wr_idx, ri_inc;
    int unsigned       wsum;

    assign full  = (cnt_q == CNT_W'(DEPTH));
    assign empty = (cnt_q == '0);
    assign acc   = push && !full;
    assign take  = pop && !empty;

    always_comb begin
        wsum = int'(ri_q) + int'(cnt_q);
        if (wsum >= DEPTH) wsum = wsum - DEPTH;
        wr_idx = PTR_W'(wsum);
        ri_inc = (ri_q == PTR_W'(DEPTH - 1)) ? '0 : ri_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ri_q  <= '0;
            cnt_q <= '0;
            ovf   <= 1'b0;
            for (int k = 0; k < DEPTH; k++) slot[k] <= '0;
        end else begin
            ovf <= push && full;
            if (acc) slot[wr_idx] <= push_data;
            if (take) ri_q <= ri_inc;
            if (acc && !take)      cnt_q <= cnt_q + 1'b1;
            else if (take && !acc) cnt_q <= cnt_q - 1'b1;
        end
    end

    assign fill   = cnt_q;
    assign rd_idx = ri_q;
    assign head   = slot[ri_q];
endmodule

// File: rtl/canfd_tx_sched.sv
module canfd_tx_sched
    import canfd_txs_pkg::*;
#(
    parameter int NBUF      = 32,
    parameter int EVT_DEPTH = 4,
    localparam int IDX_W = (NBUF > 1) ? $clog2(NBUF) : 1,
    localparam int PTR_W = (EVT_DEPTH > 1) ? $clog2(EVT_DEPTH) : 1,
    localparam int CNT_W = $clog2(EVT_DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   soft_rst,
    input  logic                   core_en,
    input  logic                   snoop_en,
    input  logic                   rdy_wr,
    input  logic [NBUF-1:0]        rdy_wdata,
    input  logic                   cxl_wr,
    input  logic [NBUF-1:0]        cxl_wdata,
    input  logic [NBUF*ID_W-1:0]   buf_id_flat,
    input  logic [NBUF*CTRL_W-1:0] buf_ctrl_flat,
    input  logic [TS_W-1:0]        ts_in,
    input  logic                   tx_done,
    input  logic                   evt_rd_inc,
    output logic [NBUF-1:0]        ready_req,
    output logic [NBUF-1:0]        cancel_req,
    output logic                   launch,
    output logic [IDX_W-1:0]       launch_idx,
    output logic                   cancel_irq,
    output logic                   evt_ovf_irq,
    output logic [CNT_W-1:0]       evt_fill,
    output logic [PTR_W-1:0]       evt_rd_idx,
    output logic [ID_W-1:0]        evt_id,
    output logic [DLC_W-1:0]       evt_dlc,
    output logic                   evt_fdf,
    output logic                   evt_brs,
    output logic [1:0]             evt_type,
    output logic [MM_W-1:0]        evt_marker,
    output logic [TS_W-1:0]        evt_ts
);
    txs_state_e        state_q, state_n;
    logic [NBUF-1:0]   ready_q, cancel_q, ready_n, cancel_n;
    logic [NBUF-1:0]   cxl_new, cxl_eff, served, cand, flight_mask, retire_mask, rdy_set;
    logic [IDX_W-1:0]  sel_q, win_idx;
    logic              win_found, may_send, retire, cirq_q;
    logic [CTRL_W-1:0] sel_ctrl;
    logic [ID_W-1:0]   sel_id;
    txs_evt_t          new_evt, head_evt;

    // ---------------- request masks ----------------
    assign may_send    = !soft_rst && core_en && !snoop_en;
    assign flight_mask = (state_q != ST_IDLE) ? (NBUF'(1) << sel_q) : '0;
    assign rdy_set     = (rdy_wr && !snoop_en) ? rdy_wdata : '0;
    assign cxl_new     = cxl_wr ? (cxl_wdata & ready_q) : '0;
    assign cxl_eff     = cancel_q | cxl_new;
    assign served      = ready_q & cxl_eff & ~flight_mask;
    assign cand        = ready_q & ~served;
    assign retire_mask = retire ? (NBUF'(1) << sel_q) : '0;
    assign ready_n     = (ready_q & ~served & ~retire_mask) | rdy_set;
    assign cancel_n    = cxl_eff & ~served & ~retire_mask;

    txs_arbiter #(.NBUF(NBUF), .ID_W(ID_W)) u_arb (
        .cand  (cand),
        .ids   (buf_id_flat),
        .found (win_found),
        .win   (win_idx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ready_q  <= '0;
            cancel_q <= '0;
            cirq_q   <= 1'b0;
            sel_q    <= '0;
        end else begin
            ready_q  <= ready_n;
            cancel_q <= cancel_n;
            cirq_q   <= |served;
            if (state_q == ST_IDLE && may_send && win_found) sel_q <= win_idx;
        end
    end

    // ---------------- sequencer: state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:   if (may_send && win_found) state_n = ST_LAUNCH;
            ST_LAUNCH: state_n = ST_BUSY;
            ST_BUSY:   if (tx_done) state_n = ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    // ---------------- sequencer: outputs ----------------
    always_comb begin
        launch = 1'b0;
        retire = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_LAUNCH: launch = 1'b1;
            ST_BUSY:   retire = tx_done;
            default:   ;
        endcase
    end

    // ---------------- event log ----------------
    assign sel_ctrl = buf_ctrl_flat[sel_q*CTRL_W +: CTRL_W];
    assign sel_id   = buf_id_flat[sel_q*ID_W +: ID_W];

    always_comb begin
        new_evt.id     = sel_id;
        new_evt.dlc    = sel_ctrl[DLC_W-1:0];
        new_evt.fdf    = sel_ctrl[CB_FDF];
        new_evt.brs    = sel_ctrl[CB_BRS];
        new_evt.kind   = EVT_KIND_SENT;
        new_evt.marker = sel_ctrl[CB_MM +: MM_W];
        new_evt.ts     = ts_in;
    end

    txs_evt_fifo #(.DEPTH(EVT_DEPTH)) u_log (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (retire && sel_ctrl[CB_LOG]),
        .push_data (new_evt),
        .pop       (evt_rd_inc),
        .fill      (evt_fill),
        .rd_idx    (evt_rd_idx),
        .head      (head_evt),
        .ovf       (evt_ovf_irq)
    );

    assign ready_req  = ready_q;
    assign cancel_req = cancel_q;
    assign launch_idx = sel_q;
    assign cancel_irq = cirq_q;
    assign evt_id     = head_evt.id;
    assign evt_dlc    = head_evt.dlc;
    assign evt_fdf    = head_evt.fdf;
    assign evt_brs    = head_evt.brs;
    assign evt_type   = head_evt.kind;
    assign evt_marker = head_evt.marker;
    assign evt_ts     = head_evt.ts;
endmodule

// File: rtl/canfd_tx_sched_chk.sv
module canfd_tx_sched_chk #(
    parameter int NBUF      = 32,
    parameter int EVT_DEPTH = 4,
    localparam int CNT_W = $clog2(EVT_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             soft_rst,
    input logic             core_en,
    input logic             snoop_en,
    input logic [NBUF-1:0]  ready_req,
    input logic [NBUF-1:0]  cancel_req,
    input logic             launch,
    input logic             evt_ovf_irq,
    input logic [CNT_W-1:0] evt_fill
);
    a_r3_cancel_within_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (cancel_req & ~ready_req) == '0);

    a_r4_launch_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> !launch);

    a_r5_launch_needs_permit: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> $past(!soft_rst && core_en && !snoop_en));

    a_r6_snoop_no_new_ready: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_en |=> ((ready_req & ~$past(ready_req)) == '0));

    a_r9_drop_only_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        evt_ovf_irq |-> ($past(evt_fill) == CNT_W'(EVT_DEPTH)));

    a_r10_fill_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        evt_fill <= CNT_W'(EVT_DEPTH));
endmodule

bind canfd_tx_sched canfd_tx_sched_chk #(.NBUF(NBUF), .EVT_DEPTH(EVT_DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_rst    (soft_rst),
    .core_en     (core_en),
    .snoop_en    (snoop_en),
    .ready_req   (ready_req),
    .cancel_req  (cancel_req),
    .launch      (launch),
    .evt_ovf_irq (evt_ovf_irq),
    .evt_fill    (evt_fill)
);

// File: tb/canfd_tx_sched_bench.sv
`timescale 1ns/1ps
module canfd_tx_sched_bench;
    import canfd_txs_pkg::*;

    localparam int NBUF  = 32;
    localparam int DEPTH = 4;
    localparam int IDX_W = $clog2(NBUF);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic soft_rst = 0, core_en = 0, snoop_en = 0;
    logic rdy_wr = 0, cxl_wr = 0, tx_done = 0, evt_rd_inc = 0;
    logic [NBUF-1:0] rdy_wdata = '0, cxl_wdata = '0;
    logic [NBUF*ID_W-1:0]   buf_id_flat = '0;
    logic [NBUF*CTRL_W-1:0] buf_ctrl_flat = '0;
    logic [TS_W-1:0] ts_in = '0;

    logic [NBUF-1:0]  ready_req, cancel_req;
    logic             launch, cancel_irq, evt_ovf_irq, evt_fdf, evt_brs;
    logic [IDX_W-1:0] launch_idx;
    logic [CNT_W-1:0] evt_fill;
    logic [PTR_W-1:0] evt_rd_idx;
    logic [ID_W-1:0]  evt_id;
    logic [DLC_W-1:0] evt_dlc;
    logic [1:0]       evt_type;
    logic [MM_W-1:0]  evt_marker;
    logic [TS_W-1:0]  evt_ts;

    canfd_tx_sched #(.NBUF(NBUF), .EVT_DEPTH(DEPTH)) u_canfd_tx_sched (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .core_en(core_en), .snoop_en(snoop_en),
        .rdy_wr(rdy_wr), .rdy_wdata(rdy_wdata), .cxl_wr(cxl_wr), .cxl_wdata(cxl_wdata),
        .buf_id_flat(buf_id_flat), .buf_ctrl_flat(buf_ctrl_flat), .ts_in(ts_in),
        .tx_done(tx_done), .evt_rd_inc(evt_rd_inc), .ready_req(ready_req),
        .cancel_req(cancel_req), .launch(launch), .launch_idx(launch_idx),
        .cancel_irq(cancel_irq), .evt_ovf_irq(evt_ovf_irq), .evt_fill(evt_fill),
        .evt_rd_idx(evt_rd_idx), .evt_id(evt_id), .evt_dlc(evt_dlc), .evt_fdf(evt_fdf),
        .evt_brs(evt_brs), .evt_type(evt_type), .evt_marker(evt_marker), .evt_ts(evt_ts)
    );

    always #2.5 clk = ~clk;

    int checks = 0, errors = 0, cycles = 0;
    int launch_cnt = 0, cirq_cnt = 0, ovf_cnt = 0;
    bit auto_ack = 0, ack_pend = 0, force_ack = 0, done_flag = 0;

    // buffer configuration seen by bench and model
    int b_id [NBUF];
    int b_dlc[NBUF], b_fdf[NBUF], b_brs[NBUF], b_log[NBUF], b_mm[NBUF];

    task automatic apply_cfg();
        for (int i = 0; i < NBUF; i++) begin
            buf_id_flat[i*ID_W +: ID_W] = ID_W'(b_id[i]);
            buf_ctrl_flat[i*CTRL_W +: CTRL_W] =
                {MM_W'(b_mm[i]), 1'(b_log[i]), 1'(b_brs[i]), 1'(b_fdf[i]), DLC_W'(b_dlc[i])};
        end
    endtask

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference ----------------
    typedef struct { int id; int dlc; int fdf; int brs; int mm; int ts; } rec_t;
    rec_t evq[$];
    logic [NBUF-1:0] m_rdy = '0, m_cxl = '0;
    int m_phase = 0;   // 0 waiting, 1 strobe, 2 in flight
    int m_sel = 0, m_ri = 0;
    bit m_cirq = 0, m_ovf = 0;

    task automatic model_step();
        logic [NBUF-1:0] eff, hit, nr, nc;
        bit fin, do_push;
        int pre, low, pick;
        rec_t r;
        eff = m_cxl | (cxl_wr ? (cxl_wdata & m_rdy) : '0);
        hit = '0;
        for (int i = 0; i < NBUF; i++)
            if (m_rdy[i] && eff[i] && !(m_phase != 0 && i == m_sel)) hit[i] = 1'b1;
        fin = (m_phase == 2) && tx_done;
        nr = m_rdy & ~hit;
        nc = eff & ~hit;
        if (fin) begin nr[m_sel] = 1'b0; nc[m_sel] = 1'b0; end
        if (rdy_wr && !snoop_en) nr = nr | rdy_wdata;
        m_cirq = |hit;
        m_ovf = 0;
        pre = evq.size();
        do_push = 0;
        if (fin && b_log[m_sel] != 0) begin
            if (pre < DEPTH) begin
                do_push = 1;
                r.id = b_id[m_sel]; r.dlc = b_dlc[m_sel]; r.fdf = b_fdf[m_sel];
                r.brs = b_brs[m_sel]; r.mm = b_mm[m_sel]; r.ts = int'(ts_in);
            end else m_ovf = 1;
        end
        if (evt_rd_inc && pre > 0) begin
            void'(evq.pop_front());
            m_ri = (m_ri + 1) % DEPTH;
        end
        if (do_push) evq.push_back(r);
        case (m_phase)
            0: begin
                if (!soft_rst && core_en && !snoop_en && (m_rdy & ~hit) != '0) begin
                    low = 32'h7fffffff;
                    for (int i = 0; i < NBUF; i++)
                        if (m_rdy[i] && !hit[i] && b_id[i] < low) low = b_id[i];
                    pick = -1;
                    for (int i = NBUF - 1; i >= 0; i--)
                        if (m_rdy[i] && !hit[i] && b_id[i] == low) pick = i;
                    m_sel = pick;
                    m_phase = 1;
                end
            end
            1: m_phase = 2;
            default: if (fin) m_phase = 0;
        endcase
        m_rdy = nr;
        m_cxl = nc;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_rdy = '0; m_cxl = '0; m_phase = 0; m_sel = 0; m_ri = 0;
            m_cirq = 0; m_ovf = 0; evq.delete();
        end else model_step();
    end

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            cycles++;
            check(ready_req == m_rdy, "R1 ready mask", 64'(ready_req), 64'(m_rdy));
            check(cancel_req == m_cxl, "R3 cancel mask", 64'(cancel_req), 64'(m_cxl));
            check(launch == (m_phase == 1), "R4 launch strobe", 64'(launch), 64'(m_phase == 1));
            if (launch) begin
                launch_cnt++;
                check(int'(launch_idx) == m_sel, "R4 launch index", 64'(launch_idx), 64'(m_sel));
            end
            check(cancel_irq == m_cirq, "R2 cancel irq", 64'(cancel_irq), 64'(m_cirq));
            if (cancel_irq) cirq_cnt++;
            check(evt_ovf_irq == m_ovf, "R9 overflow irq", 64'(evt_ovf_irq), 64'(m_ovf));
            if (evt_ovf_irq) ovf_cnt++;
            check(int'(evt_fill) == evq.size(), "R10 fill", 64'(evt_fill), 64'(evq.size()));
            check(int'(evt_rd_idx) == m_ri, "R10 read index", 64'(evt_rd_idx), 64'(m_ri));
            if (evq.size() > 0) begin
                check(int'(evt_id) == evq[0].id, "R8 record id", 64'(evt_id), 64'(evq[0].id));
                check(int'(evt_dlc) == evq[0].dlc && int'(evt_fdf) == evq[0].fdf &&
                      int'(evt_brs) == evq[0].brs, "R8 record dlc/flags",
                      64'({evt_dlc, evt_fdf, evt_brs}), 64'({4'(evq[0].dlc), 1'(evq[0].fdf), 1'(evq[0].brs)}));
                check(int'(evt_marker) == evq[0].mm, "R8 record marker", 64'(evt_marker), 64'(evq[0].mm));
                check(evt_type == 2'd3, "R8 record type", 64'(evt_type), 64'd3);
                check(int'(evt_ts) == evq[0].ts, "R8 record timestamp", 64'(evt_ts), 64'(evq[0].ts));
            end
            if (cycles > 150000) begin
                errors++;
                $display("FAIL watchdog expired");
                done_flag = 1;
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    // completion responder and timestamp source
    always @(negedge clk) begin
        ts_in = ts_in + 16'd7;
        tx_done = 1'b0;
        if (ack_pend) begin tx_done = 1'b1; ack_pend = 0; end
        else if (force_ack) begin tx_done = 1'b1; force_ack = 0; end
        else if (auto_ack && launch) ack_pend = 1;
    end

    task automatic wr_ready(input logic [NBUF-1:0] m);
        @(negedge clk); rdy_wr = 1; rdy_wdata = m;
        @(negedge clk); rdy_wr = 0; rdy_wdata = '0;
    endtask

    task automatic wr_cancel(input logic [NBUF-1:0] m);
        @(negedge clk); cxl_wr = 1; cxl_wdata = m;
        @(negedge clk); cxl_wr = 0; cxl_wdata = '0;
    endtask

    task automatic pops(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); evt_rd_inc = 1;
        end
        @(negedge clk); evt_rd_inc = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int l0, c0;
        for (int i = 0; i < NBUF; i++) begin
            b_id[i] = (i * 5) % 7;               // many equal identifiers
            b_dlc[i] = i % 16; b_fdf[i] = i % 2; b_brs[i] = (i / 2) % 2;
            b_log[i] = (i % 3 != 0) ? 1 : 0; b_mm[i] = (i * 9 + 1) % 256;
        end
        apply_cfg();
        idle(4);
        // reset state
        check(ready_req == '0 && cancel_req == '0, "R1 reset masks", 64'(ready_req), 64'd0);
        check(launch == 0 && evt_fill == 0, "R10 reset log", 64'({launch, evt_fill}), 64'd0);
        @(negedge clk); rst_n = 1;

        // pending while core disabled, then cancels
        wr_ready(32'h0000_00FF);
        idle(4);
        check(ready_req == 32'h0000_00FF, "R1 ready set", 64'(ready_req), 64'hFF);
        check(launch_cnt == 0, "R5 no launch while disabled", 64'(launch_cnt), 64'd0);
        c0 = cirq_cnt;
        wr_cancel(32'h0000_0F0F);
        idle(2);
        check(ready_req == 32'h0000_00F0, "R2 cancelled buffers cleared", 64'(ready_req), 64'hF0);
        check(cancel_req == '0, "R3 cancel on idle buffer ignored", 64'(cancel_req), 64'd0);
        check(cirq_cnt == c0 + 1, "R2 one cancel pulse", 64'(cirq_cnt), 64'(c0 + 1));

        // drain by priority
        auto_ack = 1; core_en = 1;
        idle(30);
        check(ready_req == '0, "R7 all sent buffers retired", 64'(ready_req), 64'd0);
        check(launch_cnt == 4, "R4 four launches", 64'(launch_cnt), 64'd4);
        pops(6);

        // listen-only mode ignores ready writes
        snoop_en = 1;
        wr_ready(32'hFFFF_FFFF);
        idle(3);
        check(ready_req == '0, "R6 snoop ignores ready write", 64'(ready_req), 64'd0);
        snoop_en = 0;

        // soft reset blocks launch; then many logged completions overflow
        soft_rst = 1;
        l0 = launch_cnt;
        wr_ready(32'hFFFF_0000);
        idle(5);
        check(launch_cnt == l0, "R5 soft reset blocks launch", 64'(launch_cnt), 64'(l0));
        soft_rst = 0;
        idle(100);
        check(ready_req == '0, "R7 drained after soft reset", 64'(ready_req), 64'd0);
        check(ovf_cnt > 0, "R9 overflow seen", 64'(ovf_cnt), 64'd1);
        check(int'(evt_fill) == DEPTH, "R9 log full", 64'(evt_fill), 64'(DEPTH));
        pops(3);

        // cancel on in-flight buffer is held
        auto_ack = 0;
        wr_ready(32'h0010_0000);
        idle(3);
        c0 = cirq_cnt;
        wr_cancel(32'h0010_0000);
        idle(2);
        check(ready_req[20] && cancel_req[20], "R7 in-flight cancel held", 64'({ready_req[20], cancel_req[20]}), 64'd3);
        force_ack = 1;
        idle(3);
        check(!ready_req[20] && !cancel_req[20] && cirq_cnt == c0, "R7 retire clears held cancel",
              64'({ready_req[20], cancel_req[20]}), 64'd0);

        // new identifiers, interleaved reads across the wrap
        for (int i = 0; i < NBUF; i++) begin
            b_id[i] = 29'h1FFF_FFF0 - (i * 3) % 17 * 1000;
            b_log[i] = 1;
        end
        @(negedge clk); apply_cfg();
        auto_ack = 1;
        wr_ready('1);
        for (int k = 0; k < 60; k++) begin
            @(negedge clk); evt_rd_inc = ($urandom % 3 == 0);
            idle(2);
        end
        evt_rd_inc = 0;
        idle(20);
        check(ready_req == '0, "R4 all buffers launched", 64'(ready_req), 64'd0);
        pops(8);
        check(evt_fill == '0, "R10 log emptied", 64'(evt_fill), 64'd0);

        done_flag = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule